// File: doc/BRIEF.md
# Ready-Latency-One Video Stream Stage

This block sits in a streaming video path with one input port and one output port. Each port carries ready, valid, data, start-of-packet and end-of-packet. On both ports the ready signal runs one cycle ahead of the transfer. A sink raises ready in one cycle, and a beat moves only in the next cycle, when valid is high. Each packet opens with one beat whose low four data bits give the packet type, and 0 marks video. Pixel beats follow in raster order. Each pixel beat carries all colour components side by side in one data word. End-of-packet marks the last beat.

The stage forwards every accepted beat with a fixed latency of three cycles. It applies a stand-in per-pixel operation, a bitwise complement of the pixel word, to video pixels only. A type beat and every beat of a non-video packet pass through untouched. Column and row counters find the end of each image row and the end of each frame. After a row end the stage holds input ready low for a parameter number of cycles. After a frame end it uses a second parameter. The output side obeys downstream ready with the same one-cycle latency. A skid store catches beats that are still in the pipeline when downstream ready falls.

Top module: `vstream_stage`

## Requirements
- R1: While `rst` is high, `in_rdy` is low. A beat is accepted only in a cycle where `in_vld` is high and `in_rdy` was high in the previous cycle. An `in_vld` pulse in any other cycle is ignored and produces no output beat.
- R2: The start-of-packet beat comes out unchanged, with `out_sop` high. Its data bits [3:0] hold the packet type, and type 0 means a video packet.
- R3: In a video packet with `INVERT`=1, each later beat comes out with its whole `DW`-bit data word bitwise complemented. This complements every colour component.
- R4: When `out_rdy` is held high, a beat accepted in cycle t appears on `out_vld` in cycle t+3.
- R5: Cycles in which `in_vld` is low after a high `in_rdy` lose no beat and duplicate no beat. The output order equals the acceptance order.
- R6: In a video packet, the pixel that completes a row of `FRAME_W` pixels (other than the last row) drives `in_rdy` low for exactly `ROW_GAP` cycles, starting the next cycle. `in_rdy` then returns high, provided there is room in the store.
- R7: The pixel numbered `FRAME_W*FRAME_H` of a video packet drives `in_rdy` low for exactly `FRAME_GAP` cycles, starting the next cycle.
- R8: The pixel beats of a non-type-0 packet come out unmodified and advance no row or column count, so they cause no ready gap.
- R9: `out_vld` is high only in a cycle after `out_rdy` was high. No beat is dropped under any `out_rdy` pattern. When the store cannot absorb the beats in flight, `in_rdy` is low.
- R10: `out_sop` and `out_eop` travel with the data word of the beat they arrived with.
- R11: While `rst` is high, and for the first three cycles after it falls, `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_rdy | output | 1 | Stage can take a beat in the next cycle |
| in_vld | input | 1 | Input beat present |
| in_data | input | DW | Input type word or pixel word |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| out_rdy | input | 1 | Downstream can take a beat in the next cycle |
| out_vld | output | 1 | Output beat present |
| out_data | output | DW | Output type word or pixel word |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |

## Verification
Two events can fall in the same cycle. One is a row-end or frame-end gap closing the input. The other is a beat that the previous cycle's high ready still allows in. The bench provokes this by sending the first beat of the next row, or the type beat of the next packet, in the cycle right after a row-ending pixel. It also drives junk valid pulses throughout the gap. It judges the outcome with a cycle model of ready, which counts the gap length exactly. A scoreboard shows that the overlapping beat arrives once, and that no junk beat arrives. The second overlap is store backpressure and a gap acting together. Random `out_rdy` patterns and a long stall provoke it, and the scoreboard confirms the order.

// File: rtl/vstream_pkg.sv
package vstream_pkg;
  localparam int TYPE_W = 4;
  localparam logic [TYPE_W-1:0] TYPE_VIDEO = '0;

  // true when idx is the last position of a run of lim
  function automatic logic last_of(input int unsigned idx, input int unsigned lim);
    return (idx + 1) == lim;
  endfunction

  // length of the ready gap that follows a row end
  function automatic int unsigned gap_after(input logic frame_done,
                                            input int unsigned row_gap,
                                            input int unsigned frame_gap);
    return frame_done ? frame_gap : row_gap;
  endfunction
endpackage

// File: rtl/vss_in_ctrl.sv
module vss_in_ctrl
  import vstream_pkg::*;
#(
  parameter int FRAME_W   = 64,
  parameter int FRAME_H   = 48,
  parameter int ROW_GAP   = 2,
  parameter int FRAME_GAP = 6,
  parameter int DEPTH     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_vld,
  input  logic                       in_sop,
  input  logic [TYPE_W-1:0]          in_type,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  input  logic                       occ1,
  input  logic                       occ2,
  output logic                       in_rdy,
  output logic                       acc,
  output logic                       pix_beat,
  output logic                       row_end,
  output logic                       frame_end
);
  localparam int XW   = $clog2(FRAME_W + 1);
  localparam int YW   = $clog2(FRAME_H + 1);
  localparam int MAXG = (ROW_GAP > FRAME_GAP) ? ROW_GAP : FRAME_GAP;
  localparam int GW   = $clog2(MAXG + 1) + 1;
  localparam int SW   = $clog2(DEPTH + 1) + 2;

  logic          rdy_d;
  logic          vid_pkt;
  logic [XW-1:0] col;
  logic [YW-1:0] row;
  logic [GW-1:0] gap;
  logic [SW-1:0] demand;
  logic          room;

  assign acc       = in_vld & rdy_d;
  assign pix_beat  = acc & ~in_sop & vid_pkt;
  assign row_end   = pix_beat & last_of(32'(col), FRAME_W);
  assign frame_end = row_end & last_of(32'(row), FRAME_H);

  // beats that may still land in the store with no drain at all
  assign demand = SW'(fill) + SW'(occ1) + SW'(occ2) + SW'(rdy_d) + SW'(1);
  assign room   = demand <= SW'(DEPTH);
  assign in_rdy = ~rst & (gap == '0) & room;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_d   <= 1'b0;
      vid_pkt <= 1'b0;
      col     <= '0;
      row     <= '0;
      gap     <= '0;
    end else begin
      rdy_d <= in_rdy;
      if (acc && in_sop) begin
        vid_pkt <= (in_type == TYPE_VIDEO);
        col     <= '0;
        row     <= '0;
      end else if (pix_beat) begin
        if (row_end) begin
          col <= '0;
          if (frame_end) begin
            row     <= '0;
            vid_pkt <= 1'b0;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          col <= col + 1'b1;
        end
      end
      if (row_end)
        gap <= GW'(gap_after(frame_end, ROW_GAP, FRAME_GAP));
      else if (gap != '0)
        gap <= gap - 1'b1;
    end
  end
endmodule

// File: rtl/vss_pipe.sv
module vss_pipe #(
  parameter int DW     = 24,
  parameter int INVERT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          pix_beat,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          occ1,
  output logic          occ2,
  output logic          push,
  output logic [DW+1:0] push_beat
);
  localparam int BW = DW + 2;

  function automatic logic [DW-1:0] pix_map(input logic [DW-1:0] d);
    return (INVERT != 0) ? ~d : d;
  endfunction

  logic          v1, v2;
  logic [BW-1:0] b1, b2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= acc;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    b1 <= {in_sop, in_eop, pix_beat ? pix_map(in_data) : in_data};
    b2 <= b1;
  end

  assign occ1      = v1;
  assign occ2      = v2;
  assign push      = v2;
  assign push_beat = b2;
endmodule

// File: rtl/vss_skid.sv
module vss_skid #(
  parameter int W     = 26,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wbeat,
  input  logic                       out_rdy,
  output logic                       out_vld,
  output logic                       pop,
  output logic [W-1:0]               rbeat,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          ordy_d;

  assign out_vld = (fill != '0) & ordy_d;
  assign pop     = out_vld;
  assign rbeat   = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      fill   <= '0;
      ordy_d <= 1'b0;
    end else begin
      ordy_d <= out_rdy;
      if (push) wp <= wrap_inc(wp);
      if (pop)  rp <= wrap_inc(rp);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wbeat;
  end
endmodule

// File: rtl/vstream_stage.sv
module vstream_stage
  import vstream_pkg::*;
#(
  parameter int COMP_W     = 8,
  parameter int NCOMP      = 3,
  parameter int FRAME_W    = 64,
  parameter int FRAME_H    = 48,
  parameter int ROW_GAP    = 2,
  parameter int FRAME_GAP  = 6,
  parameter int INVERT     = 1,
  parameter int SKID_DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    in_rdy,
  input  logic                    in_vld,
  input  logic [COMP_W*NCOMP-1:0] in_data,
  input  logic                    in_sop,
  input  logic                    in_eop,
  input  logic                    out_rdy,
  output logic                    out_vld,
  output logic [COMP_W*NCOMP-1:0] out_data,
  output logic                    out_sop,
  output logic                    out_eop
);
  localparam int DW = COMP_W * NCOMP;
  localparam int BW = DW + 2;
  localparam int CW = $clog2(SKID_DEPTH + 1);

  logic          acc, pix_beat, row_end, frame_end;
  logic          occ1, occ2, push, pop;
  logic [BW-1:0] push_beat, pop_beat;
  logic [CW-1:0] fifo_fill;

  vss_in_ctrl #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .ROW_GAP(ROW_GAP),
    .FRAME_GAP(FRAME_GAP), .DEPTH(SKID_DEPTH)
  ) u_ctrl (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_sop(in_sop),
    .in_type(in_data[TYPE_W-1:0]), .fill(fifo_fill), .occ1(occ1), .occ2(occ2),
    .in_rdy(in_rdy), .acc(acc), .pix_beat(pix_beat),
    .row_end(row_end), .frame_end(frame_end)
  );

  vss_pipe #(.DW(DW), .INVERT(INVERT)) u_pipe (
    .clk(clk), .rst(rst), .acc(acc), .pix_beat(pix_beat),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .occ1(occ1), .occ2(occ2), .push(push), .push_beat(push_beat)
  );

  vss_skid #(.W(BW), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst(rst), .push(push), .wbeat(push_beat),
    .out_rdy(out_rdy), .out_vld(out_vld), .pop(pop),
    .rbeat(pop_beat), .fill(fifo_fill)
  );

  assign out_sop  = pop_beat[BW-1];
  assign out_eop  = pop_beat[BW-2];
  assign out_data = pop_beat[DW-1:0];
endmodule

// File: rtl/vstream_stage_chk.sv
module vstream_stage_chk #(
  parameter int ROW_GAP   = 2,
  parameter int FRAME_GAP = 6,
  parameter int DEPTH     = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_rdy,
  input logic                       out_rdy,
  input logic                       out_vld,
  input logic                       acc,
  input logic                       row_end,
  input logic                       frame_end,
  input logic                       push,
  input logic                       pop,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int FW = $clog2(DEPTH + 1);

  a_r1_idle_in_reset: assert property (@(posedge clk) rst |-> !in_rdy);

  a_r1_accept_needs_ready: assert property (@(posedge clk) disable iff (rst)
    acc |-> $past(in_rdy));

  a_r4_store_two_after_accept: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(acc, 2));

  a_r4_accept_reaches_store: assert property (@(posedge clk) disable iff (rst)
    acc |=> ##1 push);

  a_r9_out_after_ready: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(out_rdy));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (fill != FW'(DEPTH)));

  a_r11_quiet_in_reset: assert property (@(posedge clk) rst |-> !out_vld);

  if (ROW_GAP > 0) begin : g_row
    a_r6_row_gap: assert property (@(posedge clk) disable iff (rst)
      (row_end && !frame_end) |=> !in_rdy);
  end
  if (FRAME_GAP > 0) begin : g_frame
    a_r7_frame_gap: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> !in_rdy);
  end
endmodule

bind vstream_stage vstream_stage_chk #(
  .ROW_GAP(ROW_GAP), .FRAME_GAP(FRAME_GAP), .DEPTH(SKID_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .in_rdy(in_rdy), .out_rdy(out_rdy), .out_vld(out_vld),
  .acc(acc), .row_end(row_end), .frame_end(frame_end),
  .push(push), .pop(pop), .fill(fifo_fill)
);

// File: tb/vstream_stage_bench.sv
`timescale 1ns/1ps
module vstream_stage_bench;
  localparam int W  = 4;
  localparam int H  = 3;
  localparam int RG = 2;
  localparam int FG = 5;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_rdy, in_vld, in_sop, in_eop;
  logic [DW-1:0] in_data;
  logic          out_rdy, out_vld, out_sop, out_eop;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  vstream_stage #(
    .COMP_W(8), .NCOMP(3), .FRAME_W(W), .FRAME_H(H), .ROW_GAP(RG),
    .FRAME_GAP(FG), .INVERT(1), .SKID_DEPTH(8)
  ) u_vstream_stage (
    .clk(clk), .rst(rst), .in_rdy(in_rdy), .in_vld(in_vld), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_rdy(out_rdy), .out_vld(out_vld),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic mon_on = 1'b0, rdy_chk = 1'b0;
  int bp_mode = 0;
  logic rdy_prev = 1'b0, ordy_prev = 1'b0;
  logic [15:0] lf1 = 16'hACE1, lf2 = 16'h1D2B;

  logic [DW+1:0] q_beat[$];
  int            q_cyc[$];
  string         q_tag[$];
  logic          bvid = 1'b0;
  int            bpix = 0;
  int            gap_rem = 0;
  int            gap_load = 0;
  logic          load = 1'b0;
  string         gap_tag = "R6";
  string         load_tag = "R6";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pix_val(input int k, input logic [3:0] t);
    return DW'(k * 32'h00031507) ^ {t, 20'h5A5A5};
  endfunction

  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    #1;
    lf2 = {lf2[14:0], lf2[15] ^ lf2[13] ^ lf2[12] ^ lf2[10]};
    if (bp_mode == 0)      out_rdy = 1'b1;
    else if (bp_mode == 1) out_rdy = lf2[0] | lf2[3];
    else                   out_rdy = 1'b0;
  end

  // scoreboard and ready model, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_on) begin
      if (in_vld && rdy_prev) begin
        logic [DW+1:0] eb;
        string tg;
        if (in_sop) begin
          bvid = (in_data[3:0] == 4'd0);
          bpix = 0;
          eb = {1'b1, in_eop, in_data};
          tg = "R2";
        end else begin
          bpix++;
          if (bvid) begin
            eb = {1'b0, in_eop, ~in_data};
            tg = "R3/R10";
            if ((bpix % W) == 0 && bpix <= W * H) begin
              load     = 1'b1;
              gap_load = (bpix == W * H) ? FG : RG;
              load_tag = (bpix == W * H) ? "R7" : "R6";
            end
          end else begin
            eb = {1'b0, in_eop, in_data};
            tg = "R8/R10";
          end
        end
        q_beat.push_back(eb);
        q_cyc.push_back(cyc);
        q_tag.push_back(tg);
      end
      if (rdy_chk)
        chk(in_rdy == (gap_rem == 0), (gap_rem > 0) ? gap_tag : (bvid ? "R6" : "R8"),
            int'(in_rdy), int'(gap_rem == 0));
      if (gap_rem > 0) gap_rem--;
      if (load) begin
        gap_rem = gap_load;
        gap_tag = load_tag;
        load    = 1'b0;
      end
      if (out_vld) begin
        chk(ordy_prev, "R9", int'(ordy_prev), 1);
        if (q_beat.size() == 0) begin
          chk(1'b0, "R5", int'({out_sop, out_eop, out_data}), 0);
        end else begin
          logic [DW+1:0] eb;
          int            ac;
          string         tg;
          eb = q_beat.pop_front();
          ac = q_cyc.pop_front();
          tg = q_tag.pop_front();
          chk({out_sop, out_eop, out_data} == eb, tg,
              int'({out_sop, out_eop, out_data}), int'(eb));
          if (bp_mode == 0) chk(cyc - ac == 3, "R4", cyc - ac, 3);
        end
      end
    end
    rdy_prev  = in_rdy;
    ordy_prev = out_rdy;
  end

  task automatic send_pkt(input logic [3:0] typ, input int npix, input bit bub, input bit junk);
    for (int k = 0; k <= npix; k++) begin
      bit sent = 0;
      while (!sent) begin
        @(posedge clk); #1;
        lf1 = {lf1[14:0], lf1[15] ^ lf1[13] ^ lf1[12] ^ lf1[10]};
        if (rdy_prev && !(bub && lf1[1:0] == 2'b00)) begin
          in_vld  = 1'b1;
          in_sop  = (k == 0);
          in_eop  = (k == npix);
          in_data = (k == 0) ? {20'h0, typ} : pix_val(k, typ);
          sent    = 1;
        end else if (!rdy_prev && junk) begin
          in_vld  = 1'b1;
          in_sop  = lf1[2];
          in_eop  = lf1[3];
          in_data = 24'hC0FFEE;
        end else begin
          in_vld = 1'b0;
        end
      end
    end
    @(posedge clk); #1;
    in_vld = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (q_beat.size() != 0 && n < 400) begin
      @(posedge clk);
      n++;
    end
    repeat (4) @(posedge clk);
    chk(q_beat.size() == 0, "R5", q_beat.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    repeat (3) begin
      @(negedge clk);
      chk(!in_rdy, "R1", int'(in_rdy), 0);
      chk(!out_vld, "R11", int'(out_vld), 0);
    end
    @(posedge clk); #1;
    rst = 1'b0; mon_on = 1'b1; rdy_chk = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!out_vld, "R11", int'(out_vld), 0);
    end
    // clean video frame: latency, complement, row and frame gaps
    send_pkt(4'd0, W * H, 0, 0);
    drain();
    // bubbles plus junk pulses while ready is low
    send_pkt(4'd0, W * H, 1, 1);
    send_pkt(4'd0, W * H, 1, 1);
    drain();
    // non-video packet longer than a row, then video again
    send_pkt(4'd3, 7, 0, 1);
    send_pkt(4'd0, W * H, 0, 0);
    drain();
    // downstream backpressure
    rdy_chk = 1'b0;
    bp_mode = 1;
    send_pkt(4'd0, W * H, 1, 0);
    send_pkt(4'd5, 5, 0, 0);
    drain();
    bp_mode = 2;
    fork
      send_pkt(4'd0, W * H, 0, 0);
      begin
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(!in_rdy, "R9", int'(in_rdy), 0);
        bp_mode = 1;
      end
    join
    drain();
    bp_mode = 0;
    drain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule